// File: doc/BRIEF.md
# Mute Pin and Clock Supervisor

This block watches the sample streams headed for six DAC channels, together with the master clock and the frame clock, and decides when the external mute line must be pulled low. It can force mute for three reasons: a long run of silent frames, a clock that has stopped or changed its rate, or a request from the system. It also reports a clock-error status and emits a one-cycle resync pulse that the downstream datapath uses to realign itself after a clock-ratio disturbance.

Everything runs on a free-running reference clock. The master and frame clocks are treated as asynchronous inputs. They pass through synchronizers, and the block counts their rising edges. For each frame it counts master-clock edges and compares the total with the previous frame. A separate counter, cleared by every master-clock edge, detects that the master clock has stalled. The mute and auto-mute enables are held in a small configuration register with defined reset values. The system writes it through a write strobe.

Top module: `mute_supervisor`

## Requirements
- R1: While reset is high, and afterwards until the system writes the user-mute bit to 0, `mute_n` is 0. The user-mute bit resets to 1 and the auto-mute enable resets to 0.
- R2: `mute_n` is 0 in the cycle after any cycle in which the user-mute bit is 1 or `pwr_busy` is 1. With no mute cause active, `mute_n` is 1.
- R3: With auto-mute enabled, `mute_n` goes to 0 once ZERO_RUN consecutive `smp_valid` frames have carried zero on all NCH channels. After ZERO_RUN-1 such frames it is still 1.
- R4: One valid frame with a non-zero value on any channel releases the auto mute and restarts the zero-run count from 0.
- R5: With auto-mute disabled, zero frames never mute the output, and the zero-run count is held at 0.
- R6: At each frame-clock rising edge, the number of master-clock rising edges in the frame just ended is compared with the count for the frame before it. If the two differ by more than RATIO_TOL, `resync` pulses for exactly one cycle, `clk_err` is set and `mute_n` goes to 0. A difference of exactly RATIO_TOL does nothing.
- R7: Once set, `clk_err` clears only at the end of the second consecutive frame whose count stays within RATIO_TOL of the one before it.
- R8: If no master-clock edge is seen for STALL_CYC reference cycles, `standby` goes to 1 and `mute_n` goes to 0. The next master-clock edge clears `standby`. The configuration register keeps its contents throughout.
- R9: After reset, or after a standby period, the first two frame-clock edges only re-arm the ratio monitor. No comparison is made on them, so a changed frame length at that point raises no `resync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_in | input | 1 | Master clock, asynchronous, sampled |
| fclk_in | input | 1 | Frame clock, asynchronous, sampled; rising edge marks a frame |
| smp_valid | input | 1 | One frame of samples present on `smp_data` |
| smp_data | input | NCH*SW | Channel k occupies bits [k*SW +: SW] |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_user_mute | input | 1 | User-mute bit value written on `cfg_we` |
| cfg_auto_en | input | 1 | Auto-mute enable value written on `cfg_we` |
| pwr_busy | input | 1 | Power-up or power-down sequence in progress |
| mute_n | output | 1 | Active-low external mute line |
| clk_err | output | 1 | Clock-ratio error status |
| resync | output | 1 | One-cycle datapath resync pulse |
| standby | output | 1 | Master clock found stopped |

## Verification
The zero-run detector is driven with runs of 511 and 512 all-zero frames. These separate the threshold frame from the frame before it. Runs broken by a single non-zero word on the last or on the first channel show that every lane is watched and that the count starts again from zero. A long zero run with auto-mute off shows that the count stays cleared while the enable is low. The ratio monitor is given frame lengths of 64, 128, 160, 193 and 64 master clocks. The step of exactly 32 and the step of 33 expose an off-by-one in the tolerance, and the frames after each jump expose how long the error flag is held. A master-clock stall of 1000 cycles and one of 1400 cycles sit on either side of the timeout. Changing the frame length right after the stall shows that the monitor re-arms before it compares again.

// File: rtl/mute_sup_pkg.sv
package mute_sup_pkg;

    typedef struct packed {
        logic user_mute;
        logic auto_en;
    } sup_cfg_t;

    localparam sup_cfg_t CFG_RESET = '{user_mute: 1'b1, auto_en: 1'b0};

    // re-arm progress of the ratio monitor after reset or standby
    typedef enum logic [1:0] {
        ARM_IDLE  = 2'd0,
        ARM_FIRST = 2'd1,
        ARM_READY = 2'd2
    } arm_e;

    // stable-frame history used to release the clock-error flag
    typedef enum logic [1:0] {
        STB_NONE = 2'd0,
        STB_ONE  = 2'd1,
        STB_TWO  = 2'd2
    } stab_e;

    function automatic logic ratio_jump(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] tol);
        logic [31:0] d;
        d = (a > b) ? (a - b) : (b - a);
        return d > tol;
    endfunction

endpackage

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] rise
);
    for (genvar g = 0; g < W; g++) begin : g_lane
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-1:0], async_in[g]};
        end
        assign rise[g] = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/sup_zero_run.sv
module sup_zero_run #(
    parameter int NCH = 6,
    parameter int SW  = 24,
    parameter int RUN = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [NCH*SW-1:0] data,
    input  logic              auto_en,
    output logic              auto_mute
);
    localparam int RW = $clog2(RUN + 1);
    localparam logic [RW-1:0] RUN_V = RW'(RUN);

    logic [NCH-1:0] lane_nz;
    logic           any_nz;
    logic [RW-1:0]  run;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign lane_nz[k] = |data[k*SW +: SW];
    end
    assign any_nz = |lane_nz;

    always_ff @(posedge clk) begin
        if (rst || !auto_en) begin
            run <= '0;
        end else if (valid) begin
            if (any_nz)            run <= '0;
            else if (run != RUN_V) run <= run + RW'(1);
        end
    end

    assign auto_mute = auto_en && (run == RUN_V);

    assert_run_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        run <= RUN_V);
    assert_nonzero_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && any_nz) |=> (run == '0));
    assert_disabled_clears_R5: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> (run == '0));
endmodule

// File: rtl/sup_stall_watch.sv
module sup_stall_watch #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic mck_rise,
    output logic standby
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle    <= '0;
            standby <= 1'b0;
        end else if (mck_rise) begin
            idle    <= '0;
            standby <= 1'b0;
        end else if (idle == LIM_V) begin
            standby <= 1'b1;
        end else begin
            idle <= idle + CW'(1);
        end
    end

    assert_edge_wakes_R8: assert property (@(posedge clk) disable iff (rst)
        mck_rise |=> !standby);
    assert_idle_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        idle <= LIM_V);
endmodule

// File: rtl/sup_ratio_mon.sv
module sup_ratio_mon
    import mute_sup_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TOL   = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic mck_rise,
    input  logic frm_rise,
    input  logic rearm,
    output logic resync,
    output logic clk_err
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt, prev, cur;
    arm_e             phase;
    stab_e            stab;
    logic             jump;

    assign cur  = (mck_rise && cnt != CMAX) ? cnt + CNT_W'(1) : cnt;
    assign jump = ratio_jump(32'(cur), 32'(prev), 32'(TOL));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            prev    <= '0;
            phase   <= ARM_IDLE;
            stab    <= STB_TWO;
            clk_err <= 1'b0;
            resync  <= 1'b0;
        end else begin
            resync <= 1'b0;
            if (rearm) begin
                cnt   <= '0;
                phase <= ARM_IDLE;
            end else if (frm_rise) begin
                cnt  <= '0;
                prev <= cur;
                case (phase)
                    ARM_IDLE:  phase <= ARM_FIRST;
                    ARM_FIRST: phase <= ARM_READY;
                    default: begin
                        if (jump) begin
                            resync  <= 1'b1;
                            clk_err <= 1'b1;
                            stab    <= STB_NONE;
                        end else if (stab == STB_NONE) begin
                            stab <= STB_ONE;
                        end else begin
                            stab    <= STB_TWO;
                            clk_err <= 1'b0;
                        end
                    end
                endcase
            end else begin
                cnt <= cur;
            end
        end
    end

    assert_resync_single_R6: assert property (@(posedge clk) disable iff (rst)
        resync |=> !resync);
    assert_resync_flags_R6: assert property (@(posedge clk) disable iff (rst)
        resync |-> clk_err);
    assert_err_release_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_err) |-> ($past(stab) == STB_ONE));
    assert_arming_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (frm_rise && phase != ARM_READY) |=> !resync);
endmodule

// File: rtl/mute_supervisor.sv
module mute_supervisor
    import mute_sup_pkg::*;
#(
    parameter int NCH         = 6,
    parameter int SW          = 24,
    parameter int ZERO_RUN    = 512,
    parameter int RATIO_TOL   = 32,
    parameter int CNT_W       = 12,
    parameter int STALL_CYC   = 1250,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mclk_in,
    input  logic              fclk_in,
    input  logic              smp_valid,
    input  logic [NCH*SW-1:0] smp_data,
    input  logic              cfg_we,
    input  logic              cfg_user_mute,
    input  logic              cfg_auto_en,
    input  logic              pwr_busy,
    output logic              mute_n,
    output logic              clk_err,
    output logic              resync,
    output logic              standby
);
    sup_cfg_t   cfg_q;
    logic [1:0] rises;
    logic       mck_rise, frm_rise, auto_mute, mute_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= '{user_mute: cfg_user_mute, auto_en: cfg_auto_en};
    end

    sup_edge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in({fclk_in, mclk_in}), .rise(rises)
    );
    assign mck_rise = rises[0];
    assign frm_rise = rises[1];

    sup_zero_run #(.NCH(NCH), .SW(SW), .RUN(ZERO_RUN)) u_zero (
        .clk(clk), .rst(rst), .valid(smp_valid), .data(smp_data),
        .auto_en(cfg_q.auto_en), .auto_mute(auto_mute)
    );

    sup_stall_watch #(.LIMIT(STALL_CYC)) u_stall (
        .clk(clk), .rst(rst), .mck_rise(mck_rise), .standby(standby)
    );

    sup_ratio_mon #(.CNT_W(CNT_W), .TOL(RATIO_TOL)) u_ratio (
        .clk(clk), .rst(rst), .mck_rise(mck_rise), .frm_rise(frm_rise),
        .rearm(standby), .resync(resync), .clk_err(clk_err)
    );

    always_ff @(posedge clk) begin
        if (rst) mute_q <= 1'b0;
        else     mute_q <= !(cfg_q.user_mute || pwr_busy || clk_err || standby || auto_mute);
    end
    assign mute_n = mute_q;

    assert_user_mute_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_q.user_mute |=> !mute_n);
    assert_power_mute_R2: assert property (@(posedge clk) disable iff (rst)
        pwr_busy |=> !mute_n);
    assert_auto_mute_R3: assert property (@(posedge clk) disable iff (rst)
        auto_mute |=> !mute_n);
    assert_err_mute_R6: assert property (@(posedge clk) disable iff (rst)
        clk_err |=> !mute_n);
    assert_stall_mute_R8: assert property (@(posedge clk) disable iff (rst)
        standby |=> !mute_n);
endmodule

// File: tb/mute_supervisor_bench.sv
module mute_supervisor_bench;
    localparam int NCH = 6;
    localparam int SW  = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk = 1'b0, fclk = 1'b1;
    logic smp_valid = 1'b0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic cfg_we = 1'b0, cfg_user_mute = 1'b0, cfg_auto_en = 1'b0;
    logic pwr_busy = 1'b0;
    logic mute_n, clk_err, resync, standby;

    int checks = 0, errors = 0, nres = 0;
    int div = 0, k = 0, ratio = 64, ratio_next = 64;
    logic mclk_run = 1'b1;

    always #4 clk = ~clk;

    mute_supervisor u_mute_supervisor (
        .clk(clk), .rst(rst), .mclk_in(mclk), .fclk_in(fclk),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_we(cfg_we), .cfg_user_mute(cfg_user_mute), .cfg_auto_en(cfg_auto_en),
        .pwr_busy(pwr_busy), .mute_n(mute_n), .clk_err(clk_err),
        .resync(resync), .standby(standby)
    );

    // master clock = 8 reference cycles; frame clock moves on master falling edges
    always @(negedge clk) begin
        if (mclk_run) begin
            div = div + 1;
            if (div == 4) begin
                div  = 0;
                mclk = ~mclk;
                if (!mclk) begin
                    k = k + 1;
                    if (k >= ratio) begin
                        k = 0;
                        ratio = ratio_next;
                    end
                    fclk = (k < ratio / 2);
                end
            end
        end
    end

    always @(posedge clk) if (!rst && resync) nres <= nres + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        repeat (n) @(posedge fclk);
        repeat (10) @(negedge clk);
    endtask

    task automatic write_cfg(input logic um, input logic ae);
        @(negedge clk);
        cfg_we = 1'b1; cfg_user_mute = um; cfg_auto_en = ae;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_zero(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_data = '0;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_nz(input int ch);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = '0;
        smp_data[ch*SW +: SW] = 24'h000100;
        @(negedge clk);
        smp_valid = 1'b0; smp_data = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (6) @(negedge clk);
        check("R1 mute during reset", mute_n, 0);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        check("R1 user mute default after reset", mute_n, 0);
        write_cfg(1'b0, 1'b0);
        check("R2 no cause releases mute", mute_n, 1);
    endtask

    task automatic t_force;
        @(negedge clk); pwr_busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 power busy mutes", mute_n, 0);
        pwr_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 power busy released", mute_n, 1);
        write_cfg(1'b1, 1'b0);
        check("R2 user mute bit mutes", mute_n, 0);
        write_cfg(1'b0, 1'b0);
        check("R2 user mute cleared", mute_n, 1);
    endtask

    task automatic t_zero;
        send_zero(600);
        check("R5 auto disabled ignores zero run", mute_n, 1);
        write_cfg(1'b0, 1'b1);
        send_zero(511);
        check("R3 run of 511 does not mute", mute_n, 1);
        send_zero(1);
        check("R3 run of 512 mutes", mute_n, 0);
        send_nz(NCH - 1);
        check("R4 nonzero last channel releases", mute_n, 1);
        send_zero(511);
        check("R4 count restarted after nonzero", mute_n, 1);
        send_nz(0);
        send_zero(511);
        check("R4 nonzero first channel restarts", mute_n, 1);
        write_cfg(1'b0, 1'b0);
        write_cfg(1'b0, 1'b1);
        send_zero(1);
        check("R5 disable cleared the count", mute_n, 1);
        send_zero(511);
        check("R3 full run after re-enable mutes", mute_n, 0);
        write_cfg(1'b0, 1'b0);
        check("R5 disable lifts auto mute", mute_n, 1);
    endtask

    task automatic t_ratio;
        wait_frames(3);
        check("R9 steady clocks no resync", nres, 0);
        check("R6 steady clocks no error", clk_err, 0);
        ratio_next = 128;
        wait_frames(2);
        check("R6 jump of 64 resyncs", nres, 1);
        check("R6 jump sets clk_err", clk_err, 1);
        check("R6 jump mutes", mute_n, 0);
        wait_frames(1);
        check("R7 one stable frame keeps error", clk_err, 1);
        wait_frames(1);
        check("R7 two stable frames clear error", clk_err, 0);
        check("R7 mute released with error", mute_n, 1);
        ratio_next = 160;
        wait_frames(2);
        check("R6 step of exactly 32 ignored", nres, 1);
        check("R6 step of 32 no error", clk_err, 0);
        wait_frames(1);
        ratio_next = 193;
        wait_frames(2);
        check("R6 step of 33 resyncs", nres, 2);
        check("R6 step of 33 sets error", clk_err, 1);
        ratio_next = 64;
        wait_frames(2);
        check("R6 second jump resyncs", nres, 3);
        wait_frames(2);
        check("R7 error cleared after return", clk_err, 0);
    endtask

    task automatic t_stall;
        int base;
        @(negedge clk); mclk_run = 1'b0;
        repeat (1000) @(negedge clk);
        check("R8 short stall no standby", standby, 0);
        repeat (400) @(negedge clk);
        check("R8 long stall standby", standby, 1);
        check("R8 stall mutes", mute_n, 0);
        base = nres;
        mclk_run = 1'b1;
        ratio_next = 128;
        repeat (24) @(negedge clk);
        check("R8 edge clears standby", standby, 0);
        check("R8 config kept through standby", mute_n, 1);
        wait_frames(3);
        check("R9 re-arm hides ratio change", nres, base);
        check("R9 no error after re-arm", clk_err, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_force();
        t_zero();
        t_ratio();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule